// File: doc/BRIEF.md
# Warp Scheduler with Load-Triggered Switching

This block sits in front of a single shared SIMD execution pipeline. It tracks a fixed number of warp slots and picks one warp to issue in every cycle. A warp whose issued instruction is a memory load is parked until the memory side reports that its data has arrived. The pipeline meanwhile keeps working on the other warps, so load latency is covered by computation rather than by idle cycles.

Each resident warp holds a share of a register pool that belongs to the multiprocessor. A launch request states how many registers the new warp needs. It is taken only when a slot is empty and the pool still has that many registers free. An exit instruction moves a warp into a finished state, and a later retire request releases its slot and its registers. Decode reports the load and exit flags back in the same cycle the warp is offered, and the memory side reports a completion by warp number.

Top module: `warp_sched`

## Requirements
- R1: After reset every slot is empty, `issue_valid` is 0, `stall` is 1, `mem_err` is 0, and the whole budget of 256 registers is free, so a demand of 256 is accepted and a demand of 257 is refused.
- R2: A launch is accepted in the cycle it is presented only if an empty slot exists and the demand does not exceed the free register count. It takes the lowest-numbered empty slot, reported on `launch_slot`, and the warp can issue from the next cycle.
- R3: An accepted demand is deducted from the pool at the clock edge that ends the launch cycle. A retirement returns the slot's count at the edge where the slot becomes empty. A launch in the same cycle as a retirement is judged against the count before that return.
- R4: `issue_valid` is 1 only when some warp is eligible, and `issue_warp` always names an eligible warp. Eligible means ready, or waiting and completing in that same cycle. When no warp is eligible, `stall` is 1.
- R5: Among eligible warps, the scheduler picks the first one in increasing slot order (wrapping) after the last warp that issued. After reset the search starts at slot 0.
- R6: A warp issued with `issue_is_load`=1 becomes waiting and is not issued again until its completion arrives. The other ready warps keep issuing.
- R7: A completion for a waiting warp makes it eligible in that same cycle. If that warp issues another load in the same cycle, the completion applies first and the warp ends up waiting again, with no error.
- R8: A completion naming a warp that is not waiting leaves every slot unchanged. It causes `mem_err` to be 1 for exactly the following cycle.
- R9: A warp issued with `issue_is_exit`=1 becomes finished and is never issued again. Exit takes priority over load. A retire request for a finished warp empties its slot. A retire request for any other warp has no effect.
- R10: When every resident warp is waiting, `stall` stays 1 and `issue_valid` stays 0 until a completion arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch_valid | input | 1 | Launch request for a new warp |
| launch_regs | input | 9 | Registers demanded by the new warp |
| launch_accept | output | 1 | Launch taken in this cycle |
| launch_slot | output | 3 | Slot given to the accepted warp |
| issue_valid | output | 1 | A warp is issued this cycle |
| issue_warp | output | 3 | Warp issued this cycle |
| issue_is_load | input | 1 | Decoded instruction of the issued warp is a load |
| issue_is_exit | input | 1 | Decoded instruction of the issued warp ends it |
| mem_done_valid | input | 1 | A load completion is reported |
| mem_done_warp | input | 3 | Warp whose load completed |
| retire_valid | input | 1 | Request to release a finished warp |
| retire_warp | input | 3 | Warp to release |
| stall | output | 1 | No warp can issue this cycle |
| mem_err | output | 1 | Previous cycle carried a completion for a non-waiting warp |

## Verification
The bench fills the pool to the exact register limit and then fills every slot, so it catches an admission test written as a strict less-than or a slot finder that overwrites a busy slot. It parks warps on loads until everything is waiting and then wakes one of them. A design without the same-cycle wake-up would show a stall in the completion cycle. A design with the wrong completion-versus-load order would leave the warp ready or flag a false error. It also sends completions to ready and empty slots, sends a retire request to a warp that is still running, and retires one warp while launching another in the same cycle. A design that acts on those requests would issue parked warps, free registers too early or accept a launch that does not fit.

// File: rtl/wsched_pkg.sv
package wsched_pkg;
  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,
    SLOT_READY = 2'd1,
    SLOT_WAIT  = 2'd2,
    SLOT_DONE  = 2'd3
  } slot_st_e;
endpackage

// File: rtl/wsched_rr_pick.sv
// Round-robin selector: first requester after the last winner.
module wsched_rr_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic          found,
  output logic [IW-1:0] pick
);
  always_comb begin
    int idx;
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= N; k++) begin
      idx = (int'(last) + k) % N;
      if (!found && req[idx]) begin
        found = 1'b1;
        pick  = IW'(idx);
      end
    end
  end
endmodule

// File: rtl/wsched_admit.sv
// Admission: lowest empty slot, register demand must fit the free pool.
module wsched_admit #(
  parameter int N  = 8,
  parameter int IW = 3,
  parameter int CW = 9
) (
  input  logic          launch_valid,
  input  logic [CW-1:0] launch_regs,
  input  logic [CW-1:0] free_cnt,
  input  logic [N-1:0]  empty_vec,
  output logic          accept,
  output logic [IW-1:0] slot
);
  always_comb begin
    slot = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (empty_vec[i]) slot = IW'(i);
    end
  end

  assign accept = launch_valid && (|empty_vec) && (launch_regs <= free_cnt);
endmodule

// File: rtl/wsched_slot.sv
// One warp slot: lifecycle state plus its register reservation.
module wsched_slot
  import wsched_pkg::*;
#(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch_hit,
  input  logic [CW-1:0] launch_regs,
  input  logic          issue_hit,
  input  logic          issue_load,
  input  logic          issue_exit,
  input  logic          wake,
  input  logic          retire_hit,
  output slot_st_e      st,
  output logic [CW-1:0] regs
);
  slot_st_e      st_q, st_d;
  logic [CW-1:0] regs_q;
  logic          regs_en;

  always_comb begin
    st_d    = st_q;
    regs_en = launch_hit && (st_q == SLOT_EMPTY);
    unique case (st_q)
      SLOT_EMPTY: if (launch_hit) st_d = SLOT_READY;
      SLOT_READY, SLOT_WAIT: begin
        if (issue_hit) begin
          if (issue_exit)      st_d = SLOT_DONE;
          else if (issue_load) st_d = SLOT_WAIT;
          else                 st_d = SLOT_READY;
        end else if (wake) begin
          st_d = SLOT_READY;
        end
      end
      SLOT_DONE: if (retire_hit) st_d = SLOT_EMPTY;
      default: st_d = SLOT_EMPTY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SLOT_EMPTY;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       regs_q <= '0;
    else if (regs_en) regs_q <= launch_regs;
  end

  assign st   = st_q;
  assign regs = regs_q;
endmodule

// File: rtl/warp_sched.sv
module warp_sched
  import wsched_pkg::*;
#(
  parameter int NUM_WARPS  = 8,
  parameter int REG_BUDGET = 256,
  localparam int WID_W = $clog2(NUM_WARPS),
  localparam int CNT_W = $clog2(REG_BUDGET + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_valid,
  input  logic [CNT_W-1:0] launch_regs,
  output logic             launch_accept,
  output logic [WID_W-1:0] launch_slot,
  output logic             issue_valid,
  output logic [WID_W-1:0] issue_warp,
  input  logic             issue_is_load,
  input  logic             issue_is_exit,
  input  logic             mem_done_valid,
  input  logic [WID_W-1:0] mem_done_warp,
  input  logic             retire_valid,
  input  logic [WID_W-1:0] retire_warp,
  output logic             stall,
  output logic             mem_err
);
  slot_st_e             st_arr   [NUM_WARPS];
  logic [CNT_W-1:0]     regs_arr [NUM_WARPS];
  logic [NUM_WARPS-1:0] ready_vec, wait_vec, empty_vec, done_vec, wake_vec, elig_vec;

  logic [CNT_W-1:0] free_q, free_d;
  logic             free_en, retire_ok;
  logic [WID_W-1:0] last_q;
  logic             err_q, err_d;

  for (genvar g = 0; g < NUM_WARPS; g++) begin : g_slot
    assign ready_vec[g] = (st_arr[g] == SLOT_READY);
    assign wait_vec[g]  = (st_arr[g] == SLOT_WAIT);
    assign empty_vec[g] = (st_arr[g] == SLOT_EMPTY);
    assign done_vec[g]  = (st_arr[g] == SLOT_DONE);
    assign wake_vec[g]  = wait_vec[g] && mem_done_valid && (mem_done_warp == WID_W'(g));
    assign elig_vec[g]  = ready_vec[g] || wake_vec[g];

    wsched_slot #(.CW(CNT_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .launch_hit (launch_accept && (launch_slot == WID_W'(g))),
      .launch_regs(launch_regs),
      .issue_hit  (issue_valid && (issue_warp == WID_W'(g))),
      .issue_load (issue_is_load),
      .issue_exit (issue_is_exit),
      .wake       (wake_vec[g]),
      .retire_hit (retire_valid && (retire_warp == WID_W'(g)) && done_vec[g]),
      .st         (st_arr[g]),
      .regs       (regs_arr[g])
    );
  end

  wsched_admit #(.N(NUM_WARPS), .IW(WID_W), .CW(CNT_W)) u_admit (
    .launch_valid(launch_valid),
    .launch_regs (launch_regs),
    .free_cnt    (free_q),
    .empty_vec   (empty_vec),
    .accept      (launch_accept),
    .slot        (launch_slot)
  );

  wsched_rr_pick #(.N(NUM_WARPS), .IW(WID_W)) u_pick (
    .req  (elig_vec),
    .last (last_q),
    .found(issue_valid),
    .pick (issue_warp)
  );

  assign stall = !issue_valid;

  // Register pool bookkeeping
  assign retire_ok = retire_valid && done_vec[retire_warp];
  assign free_en   = launch_accept || retire_ok;

  always_comb begin
    free_d = free_q;
    if (launch_accept) free_d = free_d - launch_regs;
    if (retire_ok)     free_d = free_d + regs_arr[retire_warp];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       free_q <= CNT_W'(REG_BUDGET);
    else if (free_en) free_q <= free_d;
  end

  // Round-robin anchor
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           last_q <= WID_W'(NUM_WARPS - 1);
    else if (issue_valid) last_q <= issue_warp;
  end

  // Completion for a warp that is not waiting
  assign err_d = mem_done_valid && !wait_vec[mem_done_warp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign mem_err = err_q;
endmodule

// File: rtl/warp_sched_chk.sv
module warp_sched_chk #(
  parameter int NUM_WARPS  = 8,
  parameter int REG_BUDGET = 256,
  localparam int WID_W = $clog2(NUM_WARPS),
  localparam int CNT_W = $clog2(REG_BUDGET + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 launch_accept,
  input logic [CNT_W-1:0]     launch_regs,
  input logic [WID_W-1:0]     launch_slot,
  input logic                 issue_valid,
  input logic [WID_W-1:0]     issue_warp,
  input logic                 issue_is_load,
  input logic                 issue_is_exit,
  input logic                 mem_done_valid,
  input logic [WID_W-1:0]     mem_done_warp,
  input logic                 retire_valid,
  input logic [WID_W-1:0]     retire_warp,
  input logic                 stall,
  input logic                 mem_err,
  input logic [CNT_W-1:0]     free_q,
  input logic [NUM_WARPS-1:0] ready_vec,
  input logic [NUM_WARPS-1:0] wait_vec,
  input logic [NUM_WARPS-1:0] empty_vec,
  input logic [NUM_WARPS-1:0] done_vec
);
  p_budget_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    free_q <= CNT_W'(REG_BUDGET));

  p_admit_fit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    launch_accept |-> (launch_regs <= free_q) && empty_vec[launch_slot]);

  p_issue_elig_r4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> ready_vec[issue_warp] ||
      (wait_vec[issue_warp] && mem_done_valid && mem_done_warp == issue_warp));

  p_stall_none_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !(|ready_vec));

  p_load_parks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_is_load && !issue_is_exit) |=> wait_vec[$past(issue_warp)]);

  p_exit_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_is_exit) |=> done_vec[$past(issue_warp)]);

  p_retire_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_valid && done_vec[retire_warp]) |=> empty_vec[$past(retire_warp)]);

  p_spur_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_done_valid && !wait_vec[mem_done_warp]) |=> mem_err);

  p_no_false_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_done_valid && !wait_vec[mem_done_warp]) |=> !mem_err);
endmodule

bind warp_sched warp_sched_chk #(.NUM_WARPS(NUM_WARPS), .REG_BUDGET(REG_BUDGET)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .launch_accept (launch_accept),
  .launch_regs   (launch_regs),
  .launch_slot   (launch_slot),
  .issue_valid   (issue_valid),
  .issue_warp    (issue_warp),
  .issue_is_load (issue_is_load),
  .issue_is_exit (issue_is_exit),
  .mem_done_valid(mem_done_valid),
  .mem_done_warp (mem_done_warp),
  .retire_valid  (retire_valid),
  .retire_warp   (retire_warp),
  .stall         (stall),
  .mem_err       (mem_err),
  .free_q        (free_q),
  .ready_vec     (ready_vec),
  .wait_vec      (wait_vec),
  .empty_vec     (empty_vec),
  .done_vec      (done_vec)
);

// File: tb/sim_warp_sched.sv
module sim_warp_sched;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       launch_valid;
  logic [8:0] launch_regs;
  logic       launch_accept;
  logic [2:0] launch_slot;
  logic       issue_valid;
  logic [2:0] issue_warp;
  logic       issue_is_load;
  logic       issue_is_exit;
  logic       mem_done_valid;
  logic [2:0] mem_done_warp;
  logic       retire_valid;
  logic [2:0] retire_warp;
  logic       stall;
  logic       mem_err;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  warp_sched u0 (
    .clk(clk), .rst_n(rst_n),
    .launch_valid(launch_valid), .launch_regs(launch_regs),
    .launch_accept(launch_accept), .launch_slot(launch_slot),
    .issue_valid(issue_valid), .issue_warp(issue_warp),
    .issue_is_load(issue_is_load), .issue_is_exit(issue_is_exit),
    .mem_done_valid(mem_done_valid), .mem_done_warp(mem_done_warp),
    .retire_valid(retire_valid), .retire_warp(retire_warp),
    .stall(stall), .mem_err(mem_err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    launch_valid = 0; launch_regs = 0; issue_is_load = 0; issue_is_exit = 0;
    mem_done_valid = 0; mem_done_warp = 0; retire_valid = 0; retire_warp = 0;
  endtask

  // Every scenario step begins and ends 1 ns after a rising edge.
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic launch(input int regs, input bit exp_acc, input int exp_slot, input string req);
    launch_valid = 1; launch_regs = 9'(regs);
    #1;
    chk(req, "launch_accept", int'(launch_accept), int'(exp_acc));
    if (exp_acc) chk(req, "launch_slot", int'(launch_slot), exp_slot);
    step();
    launch_valid = 0; launch_regs = 0;
  endtask

  // Wait until warp w is offered, then attach the decode flags to it.
  task automatic issue_op(input int w, input bit ld, input bit ex, input string req);
    bit hit = 0;
    for (int k = 0; k < 4 && !hit; k++) begin
      #1;
      if (issue_valid && int'(issue_warp) == w) begin
        issue_is_load = ld; issue_is_exit = ex; hit = 1;
      end
      @(posedge clk); #1;
      issue_is_load = 0; issue_is_exit = 0;
    end
    chk(req, "warp offered for issue", int'(hit), 1);
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R1", "issue_valid after reset", int'(issue_valid), 0);
    chk("R1", "stall after reset", int'(stall), 1);
    chk("R1", "mem_err after reset", int'(mem_err), 0);
    chk("R1", "launch_accept idle", int'(launch_accept), 0);
    launch(257, 0, 0, "R1");
    launch(256, 1, 0, "R1");
  endtask

  task automatic t_admit();
    do_reset();
    launch(100, 1, 0, "R2");
    launch(100, 1, 1, "R2");
    launch(57, 0, 0, "R2");
    launch(56, 1, 2, "R2");
    launch(1, 0, 0, "R3");
    for (int s = 3; s < 8; s++) launch(0, 1, s, "R2");
    launch(0, 0, 0, "R2");
  endtask

  task automatic t_rr();
    int prev = 0;
    do_reset();
    launch(5, 1, 0, "R2");
    #1;
    chk("R2", "new warp issues next cycle", int'(issue_valid), 1);
    chk("R2", "new warp id", int'(issue_warp), 0);
    step();
    launch(5, 1, 1, "R2");
    launch(5, 1, 2, "R2");
    for (int k = 0; k < 7; k++) begin
      #1;
      chk("R4", "issue_valid with ready warps", int'(issue_valid), 1);
      if (k > 0) chk("R5", "round-robin order", int'(issue_warp), (prev + 1) % 3);
      prev = int'(issue_warp);
      @(posedge clk); #1;
    end
  endtask

  task automatic t_load();
    do_reset();
    launch(8, 1, 0, "R6");
    launch(8, 1, 1, "R6");
    issue_op(0, 1, 0, "R6");
    for (int k = 0; k < 2; k++) begin
      #1;
      chk("R6", "other warp keeps issuing", int'(issue_valid && issue_warp == 3'd1), 1);
      step();
    end
    #1;
    issue_is_load = 1;
    step();
    issue_is_load = 0;
    for (int k = 0; k < 2; k++) begin
      #1;
      chk("R10", "stall with all waiting", int'(stall), 1);
      chk("R10", "issue_valid with all waiting", int'(issue_valid), 0);
      step();
    end
    mem_done_valid = 1; mem_done_warp = 3'd1;
    #1;
    chk("R7", "woken warp issues same cycle", int'(issue_valid && issue_warp == 3'd1), 1);
    step();
    mem_done_valid = 0;
    #1;
    chk("R7", "woken warp stays ready", int'(issue_valid && issue_warp == 3'd1), 1);
    chk("R8", "no error on valid completion", int'(mem_err), 0);
    step();
    mem_done_valid = 1; mem_done_warp = 3'd0;
    #1;
    chk("R5", "rr after wake picks warp 0", int'(issue_warp), 0);
    step();
    mem_done_valid = 0;
    #1;
    chk("R8", "no error after valid completion", int'(mem_err), 0);
  endtask

  task automatic t_spur();
    do_reset();
    launch(4, 1, 0, "R8");
    mem_done_valid = 1; mem_done_warp = 3'd0;
    step();
    mem_done_valid = 0;
    #1;
    chk("R8", "error for ready warp", int'(mem_err), 1);
    chk("R8", "ready warp unchanged", int'(issue_valid && issue_warp == 3'd0), 1);
    step();
    #1;
    chk("R8", "error lasts one cycle", int'(mem_err), 0);
    mem_done_valid = 1; mem_done_warp = 3'd5;
    step();
    mem_done_valid = 0;
    #1;
    chk("R8", "error for empty slot", int'(mem_err), 1);
    chk("R8", "no phantom warp", int'(issue_valid && issue_warp == 3'd0), 1);
    issue_is_load = 1;
    step();
    issue_is_load = 0;
    #1;
    chk("R6", "loaded warp parked", int'(stall), 1);
    mem_done_valid = 1; mem_done_warp = 3'd0; issue_is_load = 1;
    #1;
    chk("R7", "completion wakes in same cycle", int'(issue_valid && issue_warp == 3'd0), 1);
    step();
    mem_done_valid = 0; issue_is_load = 0;
    #1;
    chk("R7", "completion first then load", int'(stall), 1);
    chk("R7", "no error on combined cycle", int'(mem_err), 0);
  endtask

  task automatic t_retire();
    do_reset();
    launch(200, 1, 0, "R9");
    launch(56, 1, 1, "R9");
    launch(1, 0, 0, "R3");
    issue_op(0, 1, 1, "R9");
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R9", "finished warp not issued", int'(issue_valid && issue_warp == 3'd1), 1);
      step();
    end
    retire_valid = 1; retire_warp = 3'd1;
    step();
    retire_valid = 0;
    #1;
    chk("R9", "retire of running warp ignored", int'(issue_valid && issue_warp == 3'd1), 1);
    launch(1, 0, 0, "R9");
    retire_valid = 1; retire_warp = 3'd0; launch_valid = 1; launch_regs = 9'd200;
    #1;
    chk("R3", "launch sees pre-return count", int'(launch_accept), 0);
    step();
    retire_valid = 0; launch_valid = 0;
    launch(200, 1, 0, "R3");
    launch(1, 0, 0, "R3");
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_admit();
    t_rr();
    t_load();
    t_spur();
    t_retire();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule